// File: doc/BRIEF.md
# Per-Processor Pending Interrupt Register Bank

This block keeps one pending-interrupt word for each processor in a multiprocessor system. Software reaches a processor's word through a 4 KB page of its own on a simple memory-mapped bus. It can read the word, knock out chosen bits with a write-one-to-clear access, or raise software interrupts with a write-one-to-set access.

A second port carries hardware interrupt events from the system interrupt controller. Each event names a priority level and whether the level is being raised or dropped. The event sets or clears the bit whose number equals that level in the word of the processor the system controller currently targets.

When a bus write and a hardware event reach the same word in one cycle, the bus clear or set is applied first and the hardware update last. Read data comes back registered, one clock after the request.

Top module: `pend_bank`

## Requirements
- R1: While reset is asserted every pending word and the read data output are zero.
- R2: The processor index of a bus access is address bits [12 +: log2(NUM_CPUS)]; address bits above that field are ignored, so each processor owns a 4 KB page and the pages alias.
- R3: The word index within a page is (address & 0xF) >> 2; address bits 1:0 and 11:4 do not affect decoding.
- R4: A read (valid high, write low) of any of the four words in a page returns, on bus_rdata one clock later, that processor's pending word as it stood in the request cycle.
- R5: A write to word 1 clears each pending bit of the addressed processor whose write-data bit is 1 and leaves the other bits alone.
- R6: A write to word 2 sets each pending bit of the addressed processor whose write-data bit is 1 and leaves the other bits alone.
- R7: A write to word 0 or word 3 changes no pending word.
- R8: A hardware event with hw_assert high and level L sets bit L of the word of the processor named by target_cpu, one clock later.
- R9: A hardware event with hw_assert low and level L clears bit L of the target processor's word, one clock later.
- R10: A hardware event touches only the processor selected by target_cpu in its own cycle; the other words keep their value.
- R11: When a bus clear or set and a hardware event hit the same word in one cycle, the hardware update to bit L wins over the bus write for that bit, and the bus write still applies to every other bit.
- R12: bus_rdata holds its last value in every cycle that carries no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the request |
| bus_wdata | input | DATA_W | Write data, one bit per pending bit |
| bus_rdata | output | DATA_W | Registered read data, valid one clock after a read |
| hw_valid | input | 1 | Hardware event present this cycle |
| hw_assert | input | 1 | 1 = raise the level bit, 0 = drop it |
| hw_level | input | log2(DATA_W) | Priority level, equal to the bit number affected |
| target_cpu | input | log2(NUM_CPUS) | Processor that receives hardware events |

## Verification
A corrupted pending word stays hidden until software reads it. The bench therefore reads back every word it touches, and a reference model checks bus_rdata on every clock, so a wrong bit shows up one clock after the next read of that page. Mistakes in page or word decoding show up as a change in a neighbouring processor's word or in a write that should have been ignored. They are caught by reading the pages nearby after the write. A wrong order between the bus and hardware updates shows only when both land on the same word in the same cycle, and that case is driven on purpose.

// File: rtl/pend_bank_pkg.sv
package pend_bank_pkg;

    // Word selected within a processor's page; only CLEAR and SET act on writes.
    typedef enum logic [1:0] {
        WSEL_NOP_LO = 2'd0,
        WSEL_CLEAR  = 2'd1,
        WSEL_SET    = 2'd2,
        WSEL_NOP_HI = 2'd3
    } word_sel_e;

    localparam int PAGE_SHIFT = 12;

endpackage

// File: rtl/pend_bank_decode.sv
module pend_bank_decode
    import pend_bank_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int ADDR_W   = 16,
    localparam int CPU_W   = $clog2(NUM_CPUS)
) (
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [CPU_W-1:0]    cpu_idx,
    output logic [NUM_CPUS-1:0] cpu_sel,
    output logic                do_clear,
    output logic                do_set,
    output logic                do_read
);

    word_sel_e word_sel;
    logic      addr_unused;

    assign cpu_idx  = bus_addr[PAGE_SHIFT +: CPU_W];
    assign word_sel = word_sel_e'(bus_addr[3:2]);

    assign do_read  = bus_valid && !bus_write;
    assign do_clear = bus_valid && bus_write && (word_sel == WSEL_CLEAR);
    assign do_set   = bus_valid && bus_write && (word_sel == WSEL_SET);

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_sel
        assign cpu_sel[i] = (cpu_idx == CPU_W'(i));
    end

    // Bits outside the page index and word index play no part in decoding.
    if (ADDR_W > PAGE_SHIFT + CPU_W) begin : g_hi
        assign addr_unused = ^{bus_addr[ADDR_W-1:PAGE_SHIFT+CPU_W],
                               bus_addr[PAGE_SHIFT-1:4], bus_addr[1:0]};
    end else begin : g_nohi
        assign addr_unused = ^{bus_addr[PAGE_SHIFT-1:4], bus_addr[1:0]};
    end

endmodule

// File: rtl/pend_bank_slot.sv
module pend_bank_slot #(
    parameter int DATA_W  = 32,
    localparam int LVL_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] cur,
    input  logic              clr_en,
    input  logic              set_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hw_en,
    input  logic              hw_set,
    input  logic [LVL_W-1:0]  hw_level,
    output logic [DATA_W-1:0] nxt
);

    // Bus update first, hardware update last (hardware wins on its bit).
    always_comb begin
        nxt = cur;
        if (clr_en) begin
            nxt = nxt & ~wdata;
        end
        if (set_en) begin
            nxt = nxt | wdata;
        end
        if (hw_en) begin
            nxt[hw_level] = hw_set;
        end
    end

endmodule

// File: rtl/pend_bank.sv
module pend_bank
    import pend_bank_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    localparam int CPU_W   = $clog2(NUM_CPUS),
    localparam int LVL_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hw_valid,
    input  logic              hw_assert,
    input  logic [LVL_W-1:0]  hw_level,
    input  logic [CPU_W-1:0]  target_cpu
);

    typedef struct packed {
        logic [NUM_CPUS-1:0][DATA_W-1:0] pend;
        logic [DATA_W-1:0]               rdata;
    } state_t;

    state_t state_d, state_q;

    logic [CPU_W-1:0]                cpu_idx;
    logic [NUM_CPUS-1:0]             cpu_sel;
    logic                            do_clear;
    logic                            do_set;
    logic                            do_read;
    logic [NUM_CPUS-1:0][DATA_W-1:0] slot_nxt;
    logic [NUM_CPUS-1:0][DATA_W-1:0] pend_vec;

    pend_bank_decode #(
        .NUM_CPUS (NUM_CPUS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cpu_idx   (cpu_idx),
        .cpu_sel   (cpu_sel),
        .do_clear  (do_clear),
        .do_set    (do_set),
        .do_read   (do_read)
    );

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_slot
        pend_bank_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .cur      (state_q.pend[i]),
            .clr_en   (do_clear && cpu_sel[i]),
            .set_en   (do_set && cpu_sel[i]),
            .wdata    (bus_wdata),
            .hw_en    (hw_valid && (target_cpu == CPU_W'(i))),
            .hw_set   (hw_assert),
            .hw_level (hw_level),
            .nxt      (slot_nxt[i])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_CPUS; i++) begin
            state_d.pend[i] = slot_nxt[i];
        end
        if (do_read) begin
            state_d.rdata = state_q.pend[cpu_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign pend_vec  = state_q.pend;

endmodule

// File: rtl/pend_bank_chk.sv
module pend_bank_chk #(
    parameter int NUM_CPUS = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    localparam int CPU_W   = $clog2(NUM_CPUS),
    localparam int LVL_W   = $clog2(DATA_W)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_valid,
    input logic                            bus_write,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_wdata,
    input logic [DATA_W-1:0]               bus_rdata,
    input logic                            hw_valid,
    input logic                            hw_assert,
    input logic [LVL_W-1:0]                hw_level,
    input logic [CPU_W-1:0]                target_cpu,
    input logic [NUM_CPUS-1:0][DATA_W-1:0] pend
);

    logic [CPU_W-1:0] a_cpu;
    logic [1:0]       a_word;
    logic             a_hw_here;

    assign a_cpu     = bus_addr[12 +: CPU_W];
    assign a_word    = bus_addr[3:2];
    assign a_hw_here = hw_valid && (target_cpu == a_cpu);

    assert_rst_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0) && (bus_rdata == '0));

    assert_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rdata == $past(pend[a_cpu]));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && a_word == 2'd1 && !a_hw_here)
        |=> pend[$past(a_cpu)] == ($past(pend[a_cpu]) & ~$past(bus_wdata)));

    assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && a_word == 2'd2 && !a_hw_here)
        |=> pend[$past(a_cpu)] == ($past(pend[a_cpu]) | $past(bus_wdata)));

    assert_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (a_word == 2'd0 || a_word == 2'd3) && !hw_valid)
        |=> $stable(pend));

    assert_hw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid && hw_assert) |=> pend[$past(target_cpu)][$past(hw_level)]);

    assert_hw_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_valid && !hw_assert) |=> !pend[$past(target_cpu)][$past(hw_level)]);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind pend_bank pend_bank_chk #(
    .NUM_CPUS (NUM_CPUS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .hw_valid   (hw_valid),
    .hw_assert  (hw_assert),
    .hw_level   (hw_level),
    .target_cpu (target_cpu),
    .pend       (pend_vec)
);

// File: tb/pend_bank_bench.sv
`timescale 1ns/1ps
module pend_bank_bench;

    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        hw_valid = 1'b0;
    logic        hw_assert = 1'b0;
    logic [4:0]  hw_level = '0;
    logic [1:0]  target_cpu = '0;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    bit [31:0] m_pend [NCPU];
    bit [31:0] m_rdata;

    always #2 clk = ~clk;

    pend_bank u_pend_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .hw_valid   (hw_valid),
        .hw_assert  (hw_assert),
        .hw_level   (hw_level),
        .target_cpu (target_cpu)
    );

    // Behavioural reference model, updated on each rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCPU; i++) m_pend[i] = '0;
            m_rdata = '0;
        end else begin
            int c;
            int w;
            c = (int'(bus_addr) / 4096) % NCPU;
            w = (int'(bus_addr) % 16) / 4;
            if (bus_valid && !bus_write) m_rdata = m_pend[c];
            if (bus_valid && bus_write && w == 1) m_pend[c] = m_pend[c] & ~bus_wdata;
            if (bus_valid && bus_write && w == 2) m_pend[c] = m_pend[c] | bus_wdata;
            if (hw_valid) begin
                if (hw_assert) m_pend[target_cpu] = m_pend[target_cpu] | (32'd1 << hw_level);
                else           m_pend[target_cpu] = m_pend[target_cpu] & ~(32'd1 << hw_level);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R4, R12).
    always @(negedge clk) begin
        if (rst_n && !done) check("R4/R12 per-cycle rdata", bus_rdata, m_rdata);
    end

    // One clock: drive at negedge, return at the following negedge.
    task automatic step(input bit bv, input bit bw, input logic [15:0] a, input logic [31:0] d,
                        input bit hv, input bit ha, input logic [4:0] lv);
        bus_valid = bv; bus_write = bw; bus_addr = a; bus_wdata = d;
        hw_valid = hv; hw_assert = ha; hw_level = lv;
        @(negedge clk);
        bus_valid = 1'b0; hw_valid = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0, 0);
    endtask

    task automatic hw(input bit ha, input logic [4:0] lv);
        step(0, 0, 16'h0, 32'h0, 1, ha, lv);
    endtask

    task automatic rd_check(input logic [15:0] a, input logic [31:0] exp, input string req);
        step(1, 0, a, 32'h0, 0, 0, 0);
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: every word reads zero after reset
        for (int i = 0; i < NCPU; i++) rd_check(16'(i * 4096), 32'h0, "R1 reset word");

        // R6: set bits on processor 1
        wr(16'h1008, 32'h0000_00A5);
        rd_check(16'h1000, 32'h0000_00A5, "R6 set");
        rd_check(16'h0000, 32'h0, "R2 other page untouched");

        // R5: clear some bits
        wr(16'h1004, 32'h0000_0005);
        rd_check(16'h1000, 32'h0000_00A0, "R5 clear");

        // R2/R3: aliased page (bit 14 ignored) and word offset 0x18 -> word 2
        wr(16'h5018, 32'h0000_0100);
        rd_check(16'h1000, 32'h0000_01A0, "R2 R3 aliased set");

        // R7: words 0 and 3 ignore writes
        wr(16'h1000, 32'hFFFF_FFFF);
        wr(16'h100C, 32'hFFFF_FFFF);
        rd_check(16'h1000, 32'h0000_01A0, "R7 ignored write");

        // R4: read through word 3 returns the same word
        rd_check(16'h100C, 32'h0000_01A0, "R4 read any word");

        // R8/R9/R10: hardware events on the target processor
        target_cpu = 2'd2;
        hw(1, 5'd9);
        rd_check(16'h2000, 32'h0000_0200, "R8 hw set");
        rd_check(16'h1000, 32'h0000_01A0, "R10 other cpu kept");
        hw(0, 5'd9);
        rd_check(16'h2000, 32'h0, "R9 hw release");
        target_cpu = 2'd3;
        hw(1, 5'd31);
        rd_check(16'h3000, 32'h8000_0000, "R10 new target");
        rd_check(16'h2000, 32'h0, "R10 old target kept");

        // R11: same-cycle bus write and hardware event, hardware wins on its bit
        step(1, 1, 16'h3008, 32'h0000_0030, 1, 0, 5'd4);
        rd_check(16'h3000, 32'h8000_0020, "R11 set vs release");
        step(1, 1, 16'h3004, 32'hFFFF_FFFF, 1, 1, 5'd0);
        rd_check(16'h3000, 32'h0000_0001, "R11 clear vs assert");

        // R4/R12: read sees the word before a same-cycle update; rdata then holds
        step(1, 0, 16'h3000, 32'h0, 1, 1, 5'd2);
        check("R4 pre-update read", bus_rdata, 32'h0000_0001);
        step(0, 0, 16'h0, 32'h0, 0, 0, 0);
        check("R12 rdata hold", bus_rdata, 32'h0000_0001);
        rd_check(16'h3000, 32'h0000_0005, "R8 after read");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule